// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block sits at the end of the decode stage of a five-stage in-order pipeline. For each of the two source operands of the instruction being decoded, it chooses which value the ALU must see next cycle. The choices are the register file read data, the result register of the execute stage, the result register of the memory-access stage, and the data that writeback is writing in this same cycle. The chosen values are registered and become the ALU operand inputs. When both later stages write the same register, the younger producer wins. Register index 0 is hard-wired to zero and never takes part in forwarding.

A load is still in execute when its data cannot be forwarded. If a decoded instruction needs that load's result, the block raises a hold for one cycle. Fetch and decode keep their state during the hold, and the execute input register takes a bubble: valid low and zero operands. On the next cycle the load has moved into the access stage, and its data is forwarded from there.

Back-pressure: `fd_hold_o` is the ready signal for the decode stage, inverted. While it is high, the upstream stages must present the same instruction again on the next cycle. The block offers no valid/ready handshake toward execute, because the execute stage always accepts.

Top module: `opfwd_unit`

## Requirements
- R1: While reset is active and after it is released, `alu_valid_o`, `alu_opa_o` and `alu_opb_o` are 0 until the first clock edge with reset inactive.
- R2: A source with no matching producer has select 0 (register file). Its operand output, one cycle later, equals that source's register file data.
- R3: A valid, writing execute-stage producer whose destination equals an enabled nonzero source gives select 1. The operand one cycle later equals the execute result.
- R4: A valid, writing access-stage producer that matches gives select 2. The operand one cycle later equals the access result, which is how load data is forwarded.
- R5: When the execute and access producers both match a source, select 1 (execute) is chosen.
- R6: A writeback with write enable set whose destination matches gives select 3 and forwards the writeback data. It has lower priority than both the access and execute producers.
- R7: An execute or access producer with valid low or write enable low never matches.
- R8: Source index 0 never matches any producer. It never causes a hold, and its operand is the register file data.
- R9: When decode is valid and a valid, writing load in execute matches an enabled nonzero source, `fd_hold_o` is high in that same cycle. On the next edge, `alu_valid_o` becomes 0 and both operands become 0.
- R10: A source whose use flag is low has select 0 and never causes a hold.
- R11: Without a hold, `alu_valid_o` on the next edge follows `dec_valid_i`. When `dec_valid_i` is low, no hold is raised.
- R12: In the cycle after a load-use hold, once the load occupies the access stage, there is no hold and the consumer's operand is the access-stage load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode stage holds a valid instruction |
| dec_src1_idx_i | input | 5 | First source register index |
| dec_src2_idx_i | input | 5 | Second source register index |
| dec_src1_use_i | input | 1 | First source is read by the instruction |
| dec_src2_use_i | input | 1 | Second source is read by the instruction |
| rf_src1_data_i | input | 32 | Register file read data for source 1 |
| rf_src2_data_i | input | 32 | Register file read data for source 2 |
| exe_valid_i | input | 1 | Execute stage instruction valid |
| exe_wr_en_i | input | 1 | Execute stage instruction writes a register |
| exe_is_load_i | input | 1 | Execute stage instruction is a load |
| exe_dst_idx_i | input | 5 | Execute stage destination index |
| exe_result_i | input | 32 | Execute stage result register |
| acc_valid_i | input | 1 | Access stage instruction valid |
| acc_wr_en_i | input | 1 | Access stage instruction writes a register |
| acc_dst_idx_i | input | 5 | Access stage destination index |
| acc_result_i | input | 32 | Access stage result (ALU result or load data) |
| wb_wr_en_i | input | 1 | Writeback writes the register file this cycle |
| wb_dst_idx_i | input | 5 | Writeback destination index |
| wb_data_i | input | 32 | Writeback data |
| fd_hold_o | output | 1 | Hold fetch and decode for this cycle |
| src1_sel_o | output | 2 | Source 1 select: 0 RF, 1 execute, 2 access, 3 writeback |
| src2_sel_o | output | 2 | Source 2 select, same encoding |
| alu_valid_o | output | 1 | Registered: ALU input instruction valid (0 = bubble) |
| alu_opa_o | output | 32 | Registered first ALU operand |
| alu_opb_o | output | 32 | Registered second ALU operand |

## Verification
The operand selection is tried with four kinds of pattern. With no producers, it shows the register file path works. With a single producer in each of the execute, access and writeback positions, it tells apart each mux input. With overlapping producers on one register, it separates the priority order. With producers that are invalid, non-writing, or aimed at index 0, it tells a real match from an index compare alone. The interlock is driven with a load followed by its consumer on either source and then the load moved into the access stage, which tells the bubble cycle from the forwarding cycle after it. It is also driven with a load whose consumer leaves the source unused or is not valid, which separates a true dependency from an index coincidence.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EXE = 2'd1,
    SEL_ACC = 2'd2,
    SEL_WB  = 2'd3
  } opsel_e;

  localparam int unsigned DEF_XLEN = 32;
  localparam int unsigned DEF_AW   = 5;
  localparam int unsigned NSRC     = 2;
endpackage

// File: rtl/opfwd_match.sv
module opfwd_match #(
  parameter int unsigned AW = 5
) (
  input  logic          prod_live,
  input  logic [AW-1:0] prod_dst,
  input  logic [AW-1:0] src_idx,
  input  logic          src_use,
  output logic          hit
);
  logic src_nonzero;

  always_comb begin
    src_nonzero = (src_idx != '0);
    hit = prod_live && src_use && src_nonzero && (prod_dst == src_idx);
  end
endmodule

// File: rtl/opfwd_operand.sv
module opfwd_operand
  import opfwd_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 5
) (
  input  logic [AW-1:0]   src_idx,
  input  logic            src_use,
  input  logic [XLEN-1:0] rf_data,
  input  logic            exe_live,
  input  logic [AW-1:0]   exe_dst,
  input  logic [XLEN-1:0] exe_data,
  input  logic            acc_live,
  input  logic [AW-1:0]   acc_dst,
  input  logic [XLEN-1:0] acc_data,
  input  logic            wb_live,
  input  logic [AW-1:0]   wb_dst,
  input  logic [XLEN-1:0] wb_data,
  output opsel_e          sel,
  output logic [XLEN-1:0] value,
  output logic            exe_hit
);
  logic hit_acc;
  logic hit_wb;

  opfwd_match #(.AW(AW)) u_m_exe (
    .prod_live(exe_live), .prod_dst(exe_dst),
    .src_idx(src_idx), .src_use(src_use), .hit(exe_hit)
  );
  opfwd_match #(.AW(AW)) u_m_acc (
    .prod_live(acc_live), .prod_dst(acc_dst),
    .src_idx(src_idx), .src_use(src_use), .hit(hit_acc)
  );
  opfwd_match #(.AW(AW)) u_m_wb (
    .prod_live(wb_live), .prod_dst(wb_dst),
    .src_idx(src_idx), .src_use(src_use), .hit(hit_wb)
  );

  // youngest producer first
  always_comb begin
    if (exe_hit)      sel = SEL_EXE;
    else if (hit_acc) sel = SEL_ACC;
    else if (hit_wb)  sel = SEL_WB;
    else              sel = SEL_RF;
  end

  always_comb begin
    unique case (sel)
      SEL_EXE: value = exe_data;
      SEL_ACC: value = acc_data;
      SEL_WB:  value = wb_data;
      default: value = rf_data;
    endcase
  end
endmodule

// File: rtl/opfwd_interlock.sv
module opfwd_interlock #(
  parameter int unsigned NS = 2
) (
  input  logic          dec_valid,
  input  logic          exe_is_load,
  input  logic [NS-1:0] exe_hits,
  output logic          hold
);
  always_comb begin
    hold = dec_valid && exe_is_load && (|exe_hits);
  end
endmodule

// File: rtl/opfwd_issue_reg.sv
module opfwd_issue_reg #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NS   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hold,
  input  logic                   dec_valid,
  input  logic [NS-1:0][XLEN-1:0] opnd_in,
  output logic                   valid_q,
  output logic [NS-1:0][XLEN-1:0] opnd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      opnd_q  <= '0;
    end else if (hold) begin
      valid_q <= 1'b0;
      opnd_q  <= '0;
    end else begin
      valid_q <= dec_valid;
      opnd_q  <= opnd_in;
    end
  end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
#(
  parameter int unsigned XLEN = DEF_XLEN,
  parameter int unsigned AW   = DEF_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid_i,
  input  logic [AW-1:0]   dec_src1_idx_i,
  input  logic [AW-1:0]   dec_src2_idx_i,
  input  logic            dec_src1_use_i,
  input  logic            dec_src2_use_i,
  input  logic [XLEN-1:0] rf_src1_data_i,
  input  logic [XLEN-1:0] rf_src2_data_i,
  input  logic            exe_valid_i,
  input  logic            exe_wr_en_i,
  input  logic            exe_is_load_i,
  input  logic [AW-1:0]   exe_dst_idx_i,
  input  logic [XLEN-1:0] exe_result_i,
  input  logic            acc_valid_i,
  input  logic            acc_wr_en_i,
  input  logic [AW-1:0]   acc_dst_idx_i,
  input  logic [XLEN-1:0] acc_result_i,
  input  logic            wb_wr_en_i,
  input  logic [AW-1:0]   wb_dst_idx_i,
  input  logic [XLEN-1:0] wb_data_i,
  output logic            fd_hold_o,
  output logic [1:0]      src1_sel_o,
  output logic [1:0]      src2_sel_o,
  output logic            alu_valid_o,
  output logic [XLEN-1:0] alu_opa_o,
  output logic [XLEN-1:0] alu_opb_o
);
  localparam int unsigned NS = NSRC;

  logic [NS-1:0][AW-1:0]   src_idx;
  logic [NS-1:0]           src_use;
  logic [NS-1:0][XLEN-1:0] rf_data;
  logic [NS-1:0][XLEN-1:0] fwd_val;
  logic [NS-1:0][XLEN-1:0] opnd_q;
  logic [NS-1:0]           exe_hits;
  opsel_e                  sel [NS];
  logic                    exe_live;
  logic                    acc_live;
  logic                    hold;

  always_comb begin
    src_idx  = {dec_src2_idx_i, dec_src1_idx_i};
    src_use  = {dec_src2_use_i, dec_src1_use_i};
    rf_data  = {rf_src2_data_i, rf_src1_data_i};
    exe_live = exe_valid_i && exe_wr_en_i;
    acc_live = acc_valid_i && acc_wr_en_i;
  end

  for (genvar s = 0; s < NS; s++) begin : g_src
    opfwd_operand #(.XLEN(XLEN), .AW(AW)) u_opnd (
      .src_idx  (src_idx[s]),
      .src_use  (src_use[s]),
      .rf_data  (rf_data[s]),
      .exe_live (exe_live),
      .exe_dst  (exe_dst_idx_i),
      .exe_data (exe_result_i),
      .acc_live (acc_live),
      .acc_dst  (acc_dst_idx_i),
      .acc_data (acc_result_i),
      .wb_live  (wb_wr_en_i),
      .wb_dst   (wb_dst_idx_i),
      .wb_data  (wb_data_i),
      .sel      (sel[s]),
      .value    (fwd_val[s]),
      .exe_hit  (exe_hits[s])
    );
  end

  opfwd_interlock #(.NS(NS)) u_lock (
    .dec_valid   (dec_valid_i),
    .exe_is_load (exe_is_load_i),
    .exe_hits    (exe_hits),
    .hold        (hold)
  );

  opfwd_issue_reg #(.XLEN(XLEN), .NS(NS)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .dec_valid (dec_valid_i),
    .opnd_in   (fwd_val),
    .valid_q   (alu_valid_o),
    .opnd_q    (opnd_q)
  );

  always_comb begin
    fd_hold_o  = hold;
    src1_sel_o = sel[0];
    src2_sel_o = sel[1];
    alu_opa_o  = opnd_q[0];
    alu_opb_o  = opnd_q[1];
  end
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid_i,
  input logic [AW-1:0]   dec_src1_idx_i,
  input logic            dec_src1_use_i,
  input logic            exe_valid_i,
  input logic            exe_wr_en_i,
  input logic            exe_is_load_i,
  input logic [AW-1:0]   exe_dst_idx_i,
  input logic [XLEN-1:0] exe_result_i,
  input logic            acc_valid_i,
  input logic            acc_wr_en_i,
  input logic [AW-1:0]   acc_dst_idx_i,
  input logic            fd_hold_o,
  input logic [1:0]      src1_sel_o,
  input logic            alu_valid_o,
  input logic [XLEN-1:0] alu_opa_o,
  input logic [XLEN-1:0] alu_opb_o
);
  logic exe_m1, acc_m1;
  assign exe_m1 = exe_valid_i && exe_wr_en_i && dec_src1_use_i &&
                  (dec_src1_idx_i != '0) && (exe_dst_idx_i == dec_src1_idx_i);
  assign acc_m1 = acc_valid_i && acc_wr_en_i && dec_src1_use_i &&
                  (dec_src1_idx_i != '0) && (acc_dst_idx_i == dec_src1_idx_i);

  a_r3_exe_sel_needs_producer: assert property (@(posedge clk) disable iff (!rst_n)
    (src1_sel_o == 2'd1) |-> (exe_valid_i && exe_wr_en_i && exe_dst_idx_i == dec_src1_idx_i));

  a_r3_exe_value: assert property (@(posedge clk) disable iff (!rst_n)
    (!fd_hold_o && src1_sel_o == 2'd1) |=> (alu_opa_o == $past(exe_result_i)));

  a_r5_younger_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_m1 && acc_m1) |-> (src1_sel_o == 2'd1));

  a_r8_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_src1_idx_i == '0) |-> (src1_sel_o == 2'd0));

  a_r9_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && exe_is_load_i && exe_m1) |-> fd_hold_o);

  a_r9_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    fd_hold_o |=> (!alu_valid_o && alu_opa_o == '0 && alu_opb_o == '0));

  a_r11_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (!fd_hold_o && dec_valid_i) |=> alu_valid_o);

  a_r11_no_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |-> !fd_hold_o);
endmodule

bind opfwd_unit opfwd_unit_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid_i),
  .dec_src1_idx_i(dec_src1_idx_i), .dec_src1_use_i(dec_src1_use_i),
  .exe_valid_i(exe_valid_i), .exe_wr_en_i(exe_wr_en_i),
  .exe_is_load_i(exe_is_load_i), .exe_dst_idx_i(exe_dst_idx_i),
  .exe_result_i(exe_result_i), .acc_valid_i(acc_valid_i),
  .acc_wr_en_i(acc_wr_en_i), .acc_dst_idx_i(acc_dst_idx_i),
  .fd_hold_o(fd_hold_o), .src1_sel_o(src1_sel_o), .alu_valid_o(alu_valid_o),
  .alu_opa_o(alu_opa_o), .alu_opb_o(alu_opb_o)
);

// File: tb/opfwd_unit_tb.sv
module opfwd_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_v, d_u1, d_u2, ex_v, ex_w, ex_ld, ac_v, ac_w, wb_w;
  logic [4:0] d_r1, d_r2, ex_rd, ac_rd, wb_rd;
  logic [31:0] rf1, rf2, ex_res, ac_res, wb_d;
  logic hold, alu_v;
  logic [1:0] sel1, sel2;
  logic [31:0] opa, opb;

  int checks = 0;
  int fails = 0;
  logic [64:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opfwd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid_i(d_v),
    .dec_src1_idx_i(d_r1), .dec_src2_idx_i(d_r2),
    .dec_src1_use_i(d_u1), .dec_src2_use_i(d_u2),
    .rf_src1_data_i(rf1), .rf_src2_data_i(rf2),
    .exe_valid_i(ex_v), .exe_wr_en_i(ex_w), .exe_is_load_i(ex_ld),
    .exe_dst_idx_i(ex_rd), .exe_result_i(ex_res),
    .acc_valid_i(ac_v), .acc_wr_en_i(ac_w), .acc_dst_idx_i(ac_rd),
    .acc_result_i(ac_res), .wb_wr_en_i(wb_w), .wb_dst_idx_i(wb_rd),
    .wb_data_i(wb_d), .fd_hold_o(hold), .src1_sel_o(sel1), .src2_sel_o(sel2),
    .alu_valid_o(alu_v), .alu_opa_o(opa), .alu_opb_o(opb)
  );

  task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    d_v = 1'b1; d_u1 = 1'b1; d_u2 = 1'b1; d_r1 = 5'd1; d_r2 = 5'd2;
    rf1 = 32'h0000_1111; rf2 = 32'h0000_2222;
    ex_v = 1'b0; ex_w = 1'b0; ex_ld = 1'b0; ex_rd = 5'd0; ex_res = 32'hE0E0_E0E0;
    ac_v = 1'b0; ac_w = 1'b0; ac_rd = 5'd0; ac_res = 32'hACAC_ACAC;
    wb_w = 1'b0; wb_rd = 5'd0; wb_d = 32'hB0B0_B0B0;
  endtask

  // inputs already set at the negedge; checks combinational outputs and queues the registered result
  task automatic step(input string tag, input logic [1:0] es1, input logic [1:0] es2,
                      input logic eh, input logic ev, input logic [31:0] ea, input logic [31:0] eb);
    #1;
    chk({tag, " sel/hold"}, {60'd0, sel1, sel2, hold}, {60'd0, es1, es2, eh});
    exp_q.push_back({ev, ea, eb});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compare registered outputs just after each capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [64:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " alu"}, {alu_v, opa, opb}, e);
      end
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R1 in reset", {alu_v, opa, opb}, 65'd0);
    rst_n = 1'b1;
    #1;
    chk("R1 after release", {alu_v, opa, opb}, 65'd0);
    @(negedge clk);

    idle(); step("R2 rf path", 2'd0, 2'd0, 1'b0, 1'b1, 32'h1111, 32'h2222);

    idle(); ex_v = 1; ex_w = 1; ex_rd = 5'd1; ex_res = 32'hAAAA_0001;
    step("R3 exe fwd", 2'd1, 2'd0, 1'b0, 1'b1, 32'hAAAA_0001, 32'h2222);

    idle(); ac_v = 1; ac_w = 1; ac_rd = 5'd2; ac_res = 32'hBBBB_0002;
    step("R4 acc fwd", 2'd0, 2'd2, 1'b0, 1'b1, 32'h1111, 32'hBBBB_0002);

    idle(); ex_v = 1; ex_w = 1; ex_rd = 5'd2; ex_res = 32'h0E0E_0002;
    ac_v = 1; ac_w = 1; ac_rd = 5'd2; ac_res = 32'h0A0A_0002;
    step("R5 exe over acc", 2'd0, 2'd1, 1'b0, 1'b1, 32'h1111, 32'h0E0E_0002);

    idle(); wb_w = 1; wb_rd = 5'd2; wb_d = 32'h5555_0002;
    ac_v = 1; ac_w = 1; ac_rd = 5'd1; ac_res = 32'h6666_0001;
    step("R6 wb fwd", 2'd2, 2'd3, 1'b0, 1'b1, 32'h6666_0001, 32'h5555_0002);

    idle(); wb_w = 1; wb_rd = 5'd1; wb_d = 32'h5555_0001;
    ac_v = 1; ac_w = 1; ac_rd = 5'd1; ac_res = 32'h7777_0001;
    step("R6 acc over wb", 2'd2, 2'd0, 1'b0, 1'b1, 32'h7777_0001, 32'h2222);

    idle(); ex_v = 0; ex_w = 1; ex_rd = 5'd1; ac_v = 1; ac_w = 0; ac_rd = 5'd2;
    step("R7 dead producers", 2'd0, 2'd0, 1'b0, 1'b1, 32'h1111, 32'h2222);

    idle(); d_r1 = 5'd0; rf1 = 32'h0; ex_v = 1; ex_w = 1; ex_ld = 1; ex_rd = 5'd0;
    ac_v = 1; ac_w = 1; ac_rd = 5'd0; wb_w = 1; wb_rd = 5'd0;
    step("R8 index zero", 2'd0, 2'd0, 1'b0, 1'b1, 32'h0, 32'h2222);

    idle(); ex_v = 1; ex_w = 1; ex_ld = 1; ex_rd = 5'd2; ex_res = 32'h0000_ADD0;
    step("R9 load-use hold", 2'd0, 2'd1, 1'b1, 1'b0, 32'h0, 32'h0);

    idle(); ac_v = 1; ac_w = 1; ac_rd = 5'd2; ac_res = 32'hD00D_0002;
    step("R12 load data fwd", 2'd0, 2'd2, 1'b0, 1'b1, 32'h1111, 32'hD00D_0002);

    idle(); d_r1 = 5'd7; ex_v = 1; ex_w = 1; ex_ld = 1; ex_rd = 5'd7; ex_res = 32'h0000_ADD7;
    step("R9 hold on src1", 2'd1, 2'd0, 1'b1, 1'b0, 32'h0, 32'h0);

    idle(); d_u1 = 0; ex_v = 1; ex_w = 1; ex_ld = 1; ex_rd = 5'd1;
    step("R10 unused src", 2'd0, 2'd0, 1'b0, 1'b1, 32'h1111, 32'h2222);

    idle(); d_v = 0; ex_v = 1; ex_w = 1; ex_ld = 1; ex_rd = 5'd1; ex_res = 32'h0000_0F0F;
    step("R11 idle decode", 2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_0F0F, 32'h2222);

    idle(); step("R11 resume", 2'd0, 2'd0, 1'b0, 1'b1, 32'h1111, 32'h2222);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard actual=%0d left expected=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule